// File: doc/BRIEF.md
# Fifth-Order Sinc Decimation Filter

This block turns a one-bit delta-sigma bitstream into signed 24-bit conversion words. A fixed divider derives a modulator sample enable from the system clock, one pulse every six clocks. At each enable the bit is mapped to +1 or -1 and fed into a cascade of five integrators. Every 64th sample closes a decimation window. On the next clock, five comb sections take the differences at the low rate. The result is normalised to a signed fraction of full scale and saturated into the output register, which is written together with a one-clock valid strobe.

The overall response is the fifth power of a length-64 moving sum with unity DC gain. An input whose period equals one output interval is therefore rejected completely. A settled flag tells the consumer when the filter memory holds no samples from before the last reset or restart. The first four words after either event come from a partly empty window. The flag rises with the fifth word. A synchronous restart input clears the whole datapath to the same state as reset.

Top module: `sinc5_decim`

## Requirements
- R1: A bit on `mod_bit` is taken once every 6 system clocks, on the 6th, 12th, ... rising edge after the edge that applied reset or restart. `out_valid` is high for the first time in the clock cycle that follows the 385th such edge, and after that exactly every 384 clocks.
- R2: Output word m (counting from 0 after reset or restart) equals S(64m+63) arithmetically shifted right by 7 and then saturated. S(n) is the fifth cascaded length-64 moving sum of the mapped inputs, in which a one counts as +1, a zero counts as -1, and samples before the restart count as 0.
- R3: The shifted value is clipped to [-8388608, 8388607]. A settled all-ones input gives 8388607 (0x7FFFFF) and a settled all-zeros input gives -8388608 (0x800000).
- R4: `out_valid` is never high in two consecutive clocks.
- R5: `settled` is low for output words 0 to 3. It rises in the same cycle as the valid strobe of word 4 and stays high until the next reset or restart.
- R6: A clock edge with `restart` high leaves `settled` and `out_valid` low and `out_word` at 0. Words that follow are computed as though no earlier samples existed.
- R7: After reset, `out_word` is 0 and `out_valid` and `settled` are low.
- R8: A bitstream with a period of 64 samples (16 ones, then 48 zeros) gives a constant settled output equal to its mean, -4194304.
- R9: Outputs stay exact over runs long enough for the internal accumulators to wrap (more than 200 samples of all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous clear of the filter state and the settling tracker |
| mod_bit | input | 1 | Modulator bitstream, sampled at the internal enable |
| out_word | output | 24 | Signed conversion result, fraction of full scale |
| out_valid | output | 1 | One-clock strobe when `out_word` is updated |
| settled | output | 1 | High once the window holds only samples taken after the last clear |

## Verification
The hardest case to reach from the ports is wraparound in the integrators. The internal sums leave their range after about two hundred constant samples, yet the output words must remain exact. The stimulus holds all ones for ten output intervals, well past that point, and checks every word against a reference model. The model is built from five plain moving sums. A step placed partway through a window, and a restart applied while the filter is settled, exercise the partial-window words and the settling timing.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;

    localparam int unsigned DEF_DIV   = 6;
    localparam int unsigned DEF_DECIM = 64;
    localparam int unsigned DEF_ORDER = 5;
    localparam int unsigned DEF_OUT_W = 24;

    // Accumulator width: sign bit, guard bit and order*log2(decimation) of growth.
    function automatic int unsigned acc_width(int unsigned order, int unsigned decim);
        return 2 + order * $clog2(decim);
    endfunction

    // Right shift that takes the full-scale gain down to the output fraction.
    function automatic int unsigned norm_shift(int unsigned order, int unsigned decim,
                                               int unsigned out_w);
        return order * $clog2(decim) - (out_w - 1);
    endfunction

    // Sample timing carried from the divider into the datapath.
    typedef struct packed {
        logic take;   // modulator bit is consumed this clock
        logic last;   // this bit closes a decimation window
    } tick_t;

endpackage

// File: rtl/sinc5_tick.sv
module sinc5_tick
    import sinc5_pkg::*;
#(
    parameter int unsigned DIV   = DEF_DIV,
    parameter int unsigned DECIM = DEF_DECIM
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    output tick_t tick
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned PW = (DECIM > 1) ? $clog2(DECIM) : 1;

    logic [DW-1:0] div_q;
    logic [PW-1:0] ph_q;

    always_comb begin
        tick.take = (div_q == DW'(DIV - 1));
        tick.last = tick.take && (ph_q == PW'(DECIM - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
            ph_q  <= '0;
        end else if (tick.take) begin
            div_q <= '0;
            ph_q  <= tick.last ? '0 : ph_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/sinc5_integ.sv
module sinc5_integ #(
    parameter int unsigned ORDER = 5,
    parameter int unsigned AW    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  logic                 take,
    input  logic                 bit_in,
    output logic signed [AW-1:0] acc_out
);
    logic signed [AW-1:0] acc_q [ORDER];
    logic signed [AW-1:0] nxt   [ORDER+1];

    // +1 for a one, -1 (all ones in two's complement) for a zero.
    assign nxt[0] = bit_in ? AW'(1) : '1;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign nxt[g+1] = acc_q[g] + nxt[g];

        always_ff @(posedge clk) begin
            if (rst || restart) begin
                acc_q[g] <= '0;
            end else if (take) begin
                acc_q[g] <= nxt[g+1];
            end
        end
    end

    assign acc_out = acc_q[ORDER-1];
endmodule

// File: rtl/sinc5_comb.sv
module sinc5_comb #(
    parameter int unsigned ORDER = 5,
    parameter int unsigned AW    = 32,
    parameter int unsigned OUT_W = 24,
    parameter int unsigned SHIFT = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  logic                 fire,
    input  logic signed [AW-1:0] acc_in,
    output logic [OUT_W-1:0]     word,
    output logic                 valid
);
    localparam logic signed [AW-1:0] HI = AW'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [AW-1:0] LO = ~HI;

    logic signed [AW-1:0] dly_q [ORDER];
    logic signed [AW-1:0] diff  [ORDER+1];
    logic signed [AW-1:0] scaled;
    logic signed [AW-1:0] clipped;

    assign diff[0] = acc_in;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign diff[g+1] = diff[g] - dly_q[g];

        always_ff @(posedge clk) begin
            if (rst || restart) begin
                dly_q[g] <= '0;
            end else if (fire) begin
                dly_q[g] <= diff[g];
            end
        end
    end

    always_comb begin
        scaled = diff[ORDER] >>> SHIFT;
        if (scaled > HI) begin
            clipped = HI;
        end else if (scaled < LO) begin
            clipped = LO;
        end else begin
            clipped = scaled;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= fire;
            if (fire) begin
                word <= clipped[OUT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/sinc5_settle.sv
module sinc5_settle #(
    parameter int unsigned ORDER = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic fire,
    output logic settled
);
    localparam int unsigned CW = $clog2(ORDER + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q   <= '0;
            settled <= 1'b0;
        end else if (fire && !settled) begin
            if (cnt_q == CW'(ORDER - 1)) begin
                settled <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sinc5_decim.sv
module sinc5_decim
    import sinc5_pkg::*;
#(
    parameter int unsigned DIV   = DEF_DIV,
    parameter int unsigned DECIM = DEF_DECIM,
    parameter int unsigned ORDER = DEF_ORDER,
    parameter int unsigned OUT_W = DEF_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] out_word,
    output logic             out_valid,
    output logic             settled
);
    localparam int unsigned AW    = acc_width(ORDER, DECIM);
    localparam int unsigned SHIFT = norm_shift(ORDER, DECIM, OUT_W);

    tick_t                tk;
    logic                 sample_en;
    logic                 fire_q;
    logic signed [AW-1:0] acc_top;

    sinc5_tick #(.DIV(DIV), .DECIM(DECIM)) tick_i (
        .clk(clk), .rst(rst), .restart(restart), .tick(tk)
    );

    assign sample_en = tk.take;

    sinc5_integ #(.ORDER(ORDER), .AW(AW)) integ_i (
        .clk(clk), .rst(rst), .restart(restart),
        .take(sample_en), .bit_in(mod_bit), .acc_out(acc_top)
    );

    // Comb stage runs one clock after the window-closing sample.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= tk.last;
        end
    end

    sinc5_comb #(.ORDER(ORDER), .AW(AW), .OUT_W(OUT_W), .SHIFT(SHIFT)) comb_i (
        .clk(clk), .rst(rst), .restart(restart), .fire(fire_q),
        .acc_in(acc_top), .word(out_word), .valid(out_valid)
    );

    sinc5_settle #(.ORDER(ORDER)) settle_i (
        .clk(clk), .rst(rst), .restart(restart), .fire(fire_q), .settled(settled)
    );
endmodule

// File: rtl/sinc5_decim_chk.sv
module sinc5_decim_chk #(
    parameter int unsigned DIV   = 6,
    parameter int unsigned DECIM = 64
) (
    input logic clk,
    input logic rst,
    input logic restart,
    input logic sample_en,
    input logic out_valid,
    input logic settled
);
    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (out_valid) begin
            gap_q  <= 16'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    sample_gap_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> !sample_en);

    // R1
    word_period_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen_q) |-> (gap_q == 16'(DIV * DECIM)));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R5
    settled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && !restart) |=> settled);

    // R5
    settled_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> out_valid);

    // R6
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!settled && !out_valid));
endmodule

bind sinc5_decim sinc5_decim_chk #(.DIV(DIV), .DECIM(DECIM)) chk_i (
    .clk(clk), .rst(rst), .restart(restart), .sample_en(sample_en),
    .out_valid(out_valid), .settled(settled)
);

// File: tb/sinc5_decim_tb_top.sv
module sinc5_decim_tb_top;
    localparam int MAXN = 1024;
    localparam int NVEC = 5;
    // vector table: pattern kind (0 ones, 1 zeros, 2 alternate, 3 step, 4 period-64) and length
    localparam int VKIND [NVEC] = '{0, 1, 2, 3, 4};
    localparam int VLEN  [NVEC] = '{640, 448, 448, 704, 640};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        mod_bit = 1'b0;
    logic [23:0] out_word;
    logic        out_valid;
    logic        settled;

    int n_chk = 0;
    int n_fail = 0;
    int pe_cnt = 0;
    int outs_seen = 0;
    int nsamp = 0;
    int test_fail = 0;
    int last_word = 0;
    int first_settled_word = 0;
    bit notch_var = 1'b0;
    bit mon_en = 1'b0;
    int x_hist [MAXN];
    int sm [5][MAXN];

    always #10 clk = ~clk;

    sinc5_decim dut_i (
        .clk(clk), .rst(rst), .restart(restart), .mod_bit(mod_bit),
        .out_word(out_word), .out_valid(out_valid), .settled(settled)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            test_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_word(int m);
        int v;
        v = sm[4][64 * m + 63] >>> 7;
        if (v > 8388607) v = 8388607;
        if (v < -8388608) v = -8388608;
        return v;
    endfunction

    task automatic push(input bit b);
        int k;
        int inp;
        int old;
        k = nsamp;
        x_hist[k] = b ? 1 : -1;
        for (int lvl = 0; lvl < 5; lvl++) begin
            inp = (lvl == 0) ? x_hist[k] : sm[lvl-1][k];
            old = (k >= 64) ? ((lvl == 0) ? x_hist[k-64] : sm[lvl-1][k-64]) : 0;
            sm[lvl][k] = ((k > 0) ? sm[lvl][k-1] : 0) + inp - old;
        end
        nsamp++;
    endtask

    function automatic bit pat_bit(int kind, int k);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return k[0];
            3: return (k >= 200);
            default: return ((k % 64) < 16);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst || restart) pe_cnt <= 0;
        else pe_cnt <= pe_cnt + 1;
    end

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            bit exp_valid;
            exp_valid = (pe_cnt >= 385) && (((pe_cnt - 1) % 384) == 0);
            if (out_valid || exp_valid) begin
                chk(out_valid == exp_valid, "R1", "valid timing", out_valid, exp_valid);
                if (out_valid && exp_valid && (64 * outs_seen + 63 < nsamp)) begin
                    chk($signed(out_word) == expect_word(outs_seen), "R2", "word value",
                        $signed(out_word), expect_word(outs_seen));
                    chk(settled == (outs_seen >= 4), "R5", "settled at word",
                        settled, outs_seen >= 4);
                    last_word = $signed(out_word);
                    if (outs_seen == 4) first_settled_word = last_word;
                    else if (outs_seen > 4 && last_word != first_settled_word) notch_var = 1'b1;
                end
                if (out_valid) outs_seen++;
            end
        end
    end

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        nsamp = 0;
        outs_seen = 0;
        test_fail = 0;
        notch_var = 1'b0;
        chk(!settled && !out_valid && out_word == 24'd0, "R6", "state after restart",
            {settled, out_valid, out_word}, 0);
    endtask

    initial begin
        #(20ns * 60000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        chk(out_word == 24'd0, "R7", "word after reset", out_word, 0);
        chk(!out_valid && !settled, "R7", "flags after reset", {out_valid, settled}, 0);
        mon_en = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            do_restart();
            for (int k = 0; k < VLEN[v]; k++) begin
                mod_bit = pat_bit(VKIND[v], k);
                push(mod_bit);
                repeat (6) @(posedge clk);
                @(negedge clk);
            end
            repeat (3) @(negedge clk);
            chk(outs_seen == VLEN[v] / 64, "R1", "word count", outs_seen, VLEN[v] / 64);
            chk(settled == 1'b1, "R5", "settled at end", settled, 1);
            case (VKIND[v])
                0: begin
                    chk(last_word == 8388607, "R3", "all-ones clip", last_word, 8388607);
                    chk(test_fail == 0, "R9", "wraparound run errors", test_fail, 0);
                end
                1: chk(last_word == -8388608, "R3", "all-zeros clip", last_word, -8388608);
                2: chk(last_word == 0, "R2", "alternating mean", last_word, 0);
                3: chk(last_word == 8388607, "R2", "step final", last_word, 8388607);
                default: begin
                    chk(!notch_var, "R8", "notch constancy", notch_var, 0);
                    chk(first_settled_word == -4194304, "R8", "notch level",
                        first_settled_word, -4194304);
                end
            endcase
        end

        // R6 restart while settled: flags clear, then history restarts from zero
        chk(settled == 1'b1, "R6", "settled before restart", settled, 1);
        do_restart();
        for (int k = 0; k < 64; k++) begin
            mod_bit = 1'b1;
            push(1'b1);
            repeat (6) @(posedge clk);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(last_word == expect_word(0), "R6", "first word after restart",
            last_word, expect_word(0));
        chk(!settled, "R5", "not settled after one word", settled, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule